// File: doc/BRIEF.md
# Framed Link Token Transmitter

This block sits between a word-oriented user source and the encoder of a serial link. It takes 32-bit words through a valid/ready handshake and emits one link token per clock. A token is either a data word or a symbolic control code such as fill, start of frame, checksum, flow state or one of several end-of-frame codes. Payload words are packed into frames that are closed by a checksum, a flow-control token that reports the local receiver's state, a status end code that reports two local flags, and a closing code that tells data frames apart from synchronisation frames.

A synchronisation request comes in two flavours. The bare flavour sends a frame with no payload. The data-bearing flavour sends a frame with exactly one word, announced by a marker token. Asking for both at once is refused and flagged. With flow control on, no frame starts while the far end asks the link to hold off or while the link is down. A frame that has already started always runs to its end. A frame whose source stalls is closed after a programmable number of fill tokens.

Every decision is registered: the token chosen in one cycle appears on `tokKind`/`tokData` in the next. `inReady`, `syncAck` and `syncErr` are combinational in the deciding cycle.

Top module: `frame_token_tx`

## Requirements
- R1: During and right after reset the output token is fill (kind 0) with zero data, and `inReady` is low. Fill is sent whenever there is nothing to send.
- R2: A data frame is sent as start (kind 1), one or more data tokens (kind 2), checksum (kind 3), flow token, status end code, and data-frame close (kind 11).
- R3: A data-bearing sync request that has a word available sends a marker (kind 12), then start, exactly one data token, checksum, flow token, status end code, and sync close (kind 10).
- R4: A bare sync request sends start, checksum, flow token, status end code and sync close (kind 10), with no data token.
- R5: The status end code is 6 + 2*`txOvf` + `notReadyLvl`, both sampled on the edge that puts that code on the output.
- R6: The flow token is STOP (kind 5) if `localStop` was high on the edge that put the checksum on the output, and GO (kind 4) otherwise.
- R7: The checksum token's data is a CRC-32 over the frame's data words in order: polynomial 0x04C11DB7, start value 0xFFFFFFFF, most significant bit first, no reflection, no final inversion. A frame with no words carries 0xFFFFFFFF.
- R8: The start token carries {`aux1`,`aux2`,`dirLvl`} in data bits 2..0, with the other bits zero. Tokens other than data, checksum and start carry zero data.
- R9: A frame holds at most MAX_WORDS (default 512) words. The checksum follows the last allowed word at once, and further words go into a new frame.
- R10: Inside a data frame, when no word arrives, fill tokens are sent. After `stallLimit` consecutive fill tokens the checksum is sent. Each accepted word restarts the count.
- R11: With `flowEn` high and either `remoteStop` high or `linkUp` low, no new frame starts, but a frame in progress completes. With `flowEn` low both signals are ignored.
- R12: When `syncBare` and `syncData` are both high between frames, no frame is sent, and `syncErr` and `syncAck` pulse together for one cycle.
- R13: A pending sync request is served at the next frame boundary, ahead of queued data, and `syncAck` pulses in the cycle its first token is chosen.
- R14: `inReady` is high only while a word can be taken as payload: in the payload phase of a data frame, or the word phase of a data-bearing sync frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Source word valid |
| inWord | input | 32 | Source word |
| inReady | output | 1 | Word accepted this cycle when valid |
| syncBare | input | 1 | Request a sync frame without payload (held until ack) |
| syncData | input | 1 | Request a sync frame with one word (held until ack) |
| syncAck | output | 1 | Sync request taken or refused |
| syncErr | output | 1 | Both sync flavours requested at once |
| flowEn | input | 1 | Flow control enable |
| remoteStop | input | 1 | Far end asks to hold off |
| linkUp | input | 1 | Link is up |
| localStop | input | 1 | Local receiver wants the far end to hold off |
| txOvf | input | 1 | Local transmit buffer overflow flag |
| notReadyLvl | input | 1 | Local not-ready level |
| aux1 | input | 1 | First user flag level |
| aux2 | input | 1 | Second user flag level |
| dirLvl | input | 1 | Direction level |
| stallLimit | input | 8 | Fill tokens allowed mid-frame before closing |
| tokKind | output | 4 | Kind of the current token |
| tokData | output | 32 | Data of the current token |

## Verification
The bound checker watches the token order on every cycle: flow token after checksum, status end code after flow, a close after the status code, start after a marker, a handshake word showing up as the next data token, zero data on pure control tokens, the per-frame word bound, and no frame starting while held off. What only the bench scenarios can show is the content that depends on history and on timing: checksum values, stall-timeout lengths, the split of a long stream into a full frame and a remainder, sync priority, and refusal of the illegal request. These are compared token by token with a behavioural model.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef enum logic [3:0] {
    TK_FILL     = 4'd0,
    TK_START    = 4'd1,
    TK_DATA     = 4'd2,
    TK_CHECK    = 4'd3,
    TK_GO       = 4'd4,
    TK_STOP     = 4'd5,
    TK_STAT0    = 4'd6,
    TK_STAT1    = 4'd7,
    TK_STAT2    = 4'd8,
    TK_STAT3    = 4'd9,
    TK_END_SYNC = 4'd10,
    TK_END_DATA = 4'd11,
    TK_MARK     = 4'd12
  } tok_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SSTART,
    ST_SWORD,
    ST_PAY,
    ST_CHECK,
    ST_FLOW,
    ST_STAT,
    ST_CLOSE
  } st_e;

  typedef struct packed {
    tok_e kind;
    logic crcClr;
    logic crcAdd;
  } strobe_t;

endpackage

// File: rtl/ftx_crc_step.sv
module ftx_crc_step #(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
  input  logic [W-1:0] crcIn,
  input  logic [W-1:0] word,
  output logic [W-1:0] crcOut
);

  always_comb begin
    logic [W-1:0] c;
    c = crcIn;
    for (int i = W - 1; i >= 0; i--) begin
      if (c[W-1] ^ word[i]) c = {c[W-2:0], 1'b0} ^ POLY;
      else                  c = {c[W-2:0], 1'b0};
    end
    crcOut = c;
  end

endmodule

// File: rtl/ftx_ctrl.sv
module ftx_ctrl
  import ftx_pkg::*;
#(
  parameter int MAX_WORDS = 512,
  parameter int TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             syncBare,
  input  logic             syncData,
  input  logic             flowEn,
  input  logic             remoteStop,
  input  logic             linkUp,
  input  logic             localStop,
  input  logic             txOvf,
  input  logic             notReadyLvl,
  input  logic [TMO_W-1:0] stallLimit,
  output strobe_t          strb,
  output logic             inReady,
  output logic             syncAck,
  output logic             syncErr
);

  localparam int CW = $clog2(MAX_WORDS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_WORDS - 1);

  st_e              st, stN;
  logic [CW-1:0]    wordCnt, wordCntN;
  logic [TMO_W-1:0] stallCnt, stallCntN;
  logic             syncFrm, syncFrmN;
  logic             stopLat, stopLatN;
  logic             holdOff;

  assign holdOff = flowEn && (remoteStop || !linkUp);

  always_comb begin
    strb      = '{kind: TK_FILL, crcClr: 1'b0, crcAdd: 1'b0};
    stN       = st;
    wordCntN  = wordCnt;
    stallCntN = stallCnt;
    syncFrmN  = syncFrm;
    stopLatN  = stopLat;
    inReady   = 1'b0;
    syncAck   = 1'b0;
    syncErr   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        wordCntN  = '0;
        stallCntN = '0;
        if (syncBare && syncData) begin
          syncAck = 1'b1;
          syncErr = 1'b1;
        end else if (!holdOff) begin
          if (syncBare) begin
            strb.kind   = TK_START;
            strb.crcClr = 1'b1;
            syncAck     = 1'b1;
            syncFrmN    = 1'b1;
            stN         = ST_CHECK;
          end else if (syncData && inValid) begin
            strb.kind = TK_MARK;
            syncAck   = 1'b1;
            syncFrmN  = 1'b1;
            stN       = ST_SSTART;
          end else if (!syncData && inValid) begin
            strb.kind   = TK_START;
            strb.crcClr = 1'b1;
            syncFrmN    = 1'b0;
            stN         = ST_PAY;
          end
        end
      end
      ST_SSTART: begin
        strb.kind   = TK_START;
        strb.crcClr = 1'b1;
        stN         = ST_SWORD;
      end
      ST_SWORD: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.kind   = TK_DATA;
          strb.crcAdd = 1'b1;
          stN         = ST_CHECK;
        end
      end
      ST_PAY: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.kind   = TK_DATA;
          strb.crcAdd = 1'b1;
          wordCntN    = wordCnt + 1'b1;
          stallCntN   = '0;
          if (wordCnt == LAST_IDX) stN = ST_CHECK;
        end else if (stallCnt == stallLimit) begin
          strb.kind = TK_CHECK;
          stopLatN  = localStop;
          stN       = ST_FLOW;
        end else begin
          stallCntN = stallCnt + 1'b1;
        end
      end
      ST_CHECK: begin
        strb.kind = TK_CHECK;
        stopLatN  = localStop;
        stN       = ST_FLOW;
      end
      ST_FLOW: begin
        strb.kind = stopLat ? TK_STOP : TK_GO;
        stN       = ST_STAT;
      end
      ST_STAT: begin
        unique case ({txOvf, notReadyLvl})
          2'b00:   strb.kind = TK_STAT0;
          2'b01:   strb.kind = TK_STAT1;
          2'b10:   strb.kind = TK_STAT2;
          default: strb.kind = TK_STAT3;
        endcase
        stN = ST_CLOSE;
      end
      ST_CLOSE: begin
        strb.kind = syncFrm ? TK_END_SYNC : TK_END_DATA;
        stN       = ST_IDLE;
      end
      default: stN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      wordCnt  <= '0;
      stallCnt <= '0;
      syncFrm  <= 1'b0;
      stopLat  <= 1'b0;
    end else begin
      st       <= stN;
      wordCnt  <= wordCntN;
      stallCnt <= stallCntN;
      syncFrm  <= syncFrmN;
      stopLat  <= stopLatN;
    end
  end

endmodule

// File: rtl/ftx_dp.sv
module ftx_dp
  import ftx_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = 32'h04C11DB7,
  parameter logic [W-1:0] INIT = 32'hFFFFFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_t      strb,
  input  logic [W-1:0] inWord,
  input  logic         aux1,
  input  logic         aux2,
  input  logic         dirLvl,
  output tok_e         tokKind,
  output logic [W-1:0] tokData
);

  logic [W-1:0] crcReg, crcNext;

  ftx_crc_step #(.W(W), .POLY(POLY)) u_crc (
    .crcIn (crcReg),
    .word  (inWord),
    .crcOut(crcNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tokKind <= TK_FILL;
      tokData <= '0;
      crcReg  <= INIT;
    end else begin
      tokKind <= strb.kind;
      unique case (strb.kind)
        TK_DATA:  tokData <= inWord;
        TK_CHECK: tokData <= crcReg;
        TK_START: tokData <= {{(W-3){1'b0}}, aux1, aux2, dirLvl};
        default:  tokData <= '0;
      endcase
      if (strb.crcClr)      crcReg <= INIT;
      else if (strb.crcAdd) crcReg <= crcNext;
    end
  end

endmodule

// File: rtl/frame_token_tx.sv
module frame_token_tx
  import ftx_pkg::*;
#(
  parameter int MAX_WORDS = 512,
  parameter int TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [31:0]      inWord,
  output logic             inReady,
  input  logic             syncBare,
  input  logic             syncData,
  output logic             syncAck,
  output logic             syncErr,
  input  logic             flowEn,
  input  logic             remoteStop,
  input  logic             linkUp,
  input  logic             localStop,
  input  logic             txOvf,
  input  logic             notReadyLvl,
  input  logic             aux1,
  input  logic             aux2,
  input  logic             dirLvl,
  input  logic [TMO_W-1:0] stallLimit,
  output logic [3:0]       tokKind,
  output logic [31:0]      tokData
);

  strobe_t strb;
  tok_e    kindE;

  ftx_ctrl #(.MAX_WORDS(MAX_WORDS), .TMO_W(TMO_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .syncBare   (syncBare),
    .syncData   (syncData),
    .flowEn     (flowEn),
    .remoteStop (remoteStop),
    .linkUp     (linkUp),
    .localStop  (localStop),
    .txOvf      (txOvf),
    .notReadyLvl(notReadyLvl),
    .stallLimit (stallLimit),
    .strb       (strb),
    .inReady    (inReady),
    .syncAck    (syncAck),
    .syncErr    (syncErr)
  );

  ftx_dp #(.W(32)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .inWord (inWord),
    .aux1   (aux1),
    .aux2   (aux2),
    .dirLvl (dirLvl),
    .tokKind(kindE),
    .tokData(tokData)
  );

  assign tokKind = kindE;

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker
  import ftx_pkg::*;
#(
  parameter int MAX_WORDS = 512
) (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [31:0] inWord,
  input logic        inReady,
  input logic        syncAck,
  input logic        syncErr,
  input logic        flowEn,
  input logic        remoteStop,
  input logic        linkUp,
  input logic [3:0]  tokKind,
  input logic [31:0] tokData
);

  logic [15:0] wordsSeen;

  always_ff @(posedge clk) begin
    if (rst)                     wordsSeen <= '0;
    else if (tokKind == TK_START) wordsSeen <= '0;
    else if (tokKind == TK_DATA)  wordsSeen <= wordsSeen + 1'b1;
  end

  // R9
  p_words_bound_r9: assert property (@(posedge clk) disable iff (rst)
    wordsSeen <= 16'(MAX_WORDS));

  // R14
  p_ready_data_r14: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (tokKind == TK_DATA && tokData == $past(inWord)));

  // R6
  p_flow_after_check_r6: assert property (@(posedge clk) disable iff (rst)
    (tokKind == TK_CHECK) |=> (tokKind == TK_GO || tokKind == TK_STOP));

  // R5
  p_stat_after_flow_r5: assert property (@(posedge clk) disable iff (rst)
    (tokKind == TK_GO || tokKind == TK_STOP) |=> (tokKind >= TK_STAT0 && tokKind <= TK_STAT3));

  // R2
  p_close_after_stat_r2: assert property (@(posedge clk) disable iff (rst)
    (tokKind >= TK_STAT0 && tokKind <= TK_STAT3) |=> (tokKind == TK_END_DATA || tokKind == TK_END_SYNC));

  // R3
  p_start_after_mark_r3: assert property (@(posedge clk) disable iff (rst)
    (tokKind == TK_MARK) |=> (tokKind == TK_START));

  // R12
  p_err_with_ack_r12: assert property (@(posedge clk) disable iff (rst)
    syncErr |-> syncAck);

  // R8
  p_zero_ctrl_data_r8: assert property (@(posedge clk) disable iff (rst)
    (tokKind != TK_DATA && tokKind != TK_CHECK && tokKind != TK_START) |-> (tokData == 32'h0));

  // R11
  p_no_start_held_r11: assert property (@(posedge clk) disable iff (rst)
    (flowEn && (remoteStop || !linkUp)) |=>
      (tokKind != TK_MARK && !(tokKind == TK_START && $past(tokKind) != TK_MARK)));

endmodule

bind frame_token_tx ftx_checker #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inWord    (inWord),
  .inReady   (inReady),
  .syncAck   (syncAck),
  .syncErr   (syncErr),
  .flowEn    (flowEn),
  .remoteStop(remoteStop),
  .linkUp    (linkUp),
  .tokKind   (tokKind),
  .tokData   (tokData)
);

// File: tb/sim_frame_token_tx.sv
`timescale 1ns/100ps
module sim_frame_token_tx;

  localparam int MAXW = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        inReady, syncAck, syncErr;
  logic        syncBare = 1'b0, syncData = 1'b0;
  logic        flowEn = 1'b0, remoteStop = 1'b0, linkUp = 1'b1, localStop = 1'b0;
  logic        txOvf = 1'b0, notReadyLvl = 1'b0;
  logic        aux1 = 1'b0, aux2 = 1'b0, dirLvl = 1'b0;
  logic [7:0]  stallLimit = 8'd4;
  logic [3:0]  tokKind;
  logic [31:0] tokData;

  frame_token_tx #(.MAX_WORDS(MAXW), .TMO_W(8)) u0 (.*);

  always #2.5 clk = ~clk;

  int nChecks = 0, nErr = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int k);
    case (k)
      0: return "R1";
      1: return "R8";
      2, 11: return "R2";
      3: return "R7";
      4, 5: return "R6";
      6, 7, 8, 9: return "R5";
      10: return "R4";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      bit top = r[31] ^ w[b];
      r = r << 1;
      if (top) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  // source and sync driver
  logic [31:0] srcQ[$];
  bit srcHold = 0, popNow = 0, ackNow = 0;

  always @(posedge clk) begin
    #2;
    if (popNow) begin
      logic [31:0] dropped;
      dropped = srcQ.pop_front();
      popNow = 0;
    end
    if (ackNow) begin
      syncBare = 1'b0;
      syncData = 1'b0;
      ackNow = 0;
    end
    inValid = (srcQ.size() != 0) && !srcHold;
    inWord  = inValid ? srcQ[0] : 32'h0;
  end

  // reference model and observers
  int mPh = 0, mKind = 0, mCnt = 0, mStall = 0;
  logic [31:0] mData = 0, mCrc = 32'hFFFFFFFF;
  bit mSyncF = 0, mStop = 0;
  int obsCnt = 0, obsIdle = 0, sofCount = 0, errCount = 0, lastClose = 0;
  bit inFrame = 0;
  int lenHist[$];
  int idleHist[$];

  always @(negedge clk) begin
    if (rst) begin
      mPh = 0; mKind = 0; mData = 0; mCrc = 32'hFFFFFFFF;
      mCnt = 0; mStall = 0; mSyncF = 0; mStop = 0;
    end else begin
      int nph, nk;
      logic [31:0] nd;
      bit gate, eRdy, eAck, eErr;
      chk(tokKind == mKind[3:0], tagOf(mKind), "token kind", tokKind, mKind);
      chk(tokData == mData, tagOf(mKind), "token data", tokData, mData);

      case (tokKind)
        4'd1: begin sofCount++; inFrame = 1; obsCnt = 0; obsIdle = 0; end
        4'd2: begin obsCnt++; obsIdle = 0; end
        4'd0: if (inFrame) obsIdle++;
        4'd3: begin lenHist.push_back(obsCnt); idleHist.push_back(obsIdle); inFrame = 0; end
        4'd10, 4'd11: lastClose = tokKind;
        default: ;
      endcase
      if (syncErr) errCount++;

      gate = flowEn && (remoteStop || !linkUp);
      eRdy = (mPh == 2 || mPh == 3);
      eAck = 0; eErr = 0; nk = 0; nd = 0; nph = mPh;
      case (mPh)
        0: begin
          mCnt = 0; mStall = 0;
          if (syncBare && syncData) begin eAck = 1; eErr = 1; end
          else if (!gate) begin
            if (syncBare) begin
              nk = 1; nd = {29'b0, aux1, aux2, dirLvl}; eAck = 1; mSyncF = 1;
              mCrc = 32'hFFFFFFFF; nph = 4;
            end else if (syncData && inValid) begin
              nk = 12; eAck = 1; mSyncF = 1; nph = 1;
            end else if (!syncData && inValid) begin
              nk = 1; nd = {29'b0, aux1, aux2, dirLvl}; mSyncF = 0;
              mCrc = 32'hFFFFFFFF; nph = 3;
            end
          end
        end
        1: begin nk = 1; nd = {29'b0, aux1, aux2, dirLvl}; mCrc = 32'hFFFFFFFF; nph = 2; end
        2: if (inValid) begin nk = 2; nd = inWord; mCrc = crcStep(mCrc, inWord); nph = 4; end
        3: begin
          if (inValid) begin
            nk = 2; nd = inWord; mCrc = crcStep(mCrc, inWord);
            mCnt++; mStall = 0;
            if (mCnt == MAXW) nph = 4;
          end else if (mStall == int'(stallLimit)) begin
            nk = 3; nd = mCrc; mStop = localStop; nph = 5;
          end else mStall++;
        end
        4: begin nk = 3; nd = mCrc; mStop = localStop; nph = 5; end
        5: begin nk = mStop ? 5 : 4; nph = 6; end
        6: begin nk = 6 + 2 * int'(txOvf) + int'(notReadyLvl); nph = 7; end
        default: begin nk = mSyncF ? 10 : 11; nph = 0; end
      endcase
      chk(inReady == eRdy, "R14", "inReady", inReady, eRdy);
      chk(syncAck == eAck, "R13", "syncAck", syncAck, eAck);
      chk(syncErr == eErr, "R12", "syncErr", syncErr, eErr);
      popNow = inValid && inReady;
      ackNow = syncAck;
      mKind = nk; mData = nd; mPh = nph;
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      summary();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) srcQ.push_back(base + 32'h01030507 * i);
  endtask

  task automatic drain();
    while (srcQ.size() != 0) cyc(1);
    cyc(25);
  endtask

  initial begin
    int s0, e0;
    cyc(3);
    chk(tokKind == 4'd0, "R1", "reset kind", tokKind, 0);
    chk(tokData == 32'h0, "R1", "reset data", tokData, 0);
    chk(inReady == 1'b0, "R1", "reset ready", inReady, 0);
    rst = 1'b0;
    cyc(5);
    chk(tokKind == 4'd0, "R1", "fill when empty", tokKind, 0);

    // plain frame, closed by stall timeout
    stallLimit = 8'd4; aux1 = 1; dirLvl = 1;
    push(3, 32'hA5000001);
    drain();
    chk(lenHist[$] == 3, "R2", "frame length", lenHist[$], 3);
    chk(idleHist[$] == 4, "R10", "fill before close", idleHist[$], 4);
    chk(lastClose == 11, "R2", "data close", lastClose, 11);

    // gapped source, no timeout, other status and flow levels
    stallLimit = 8'd2; localStop = 1; txOvf = 1; aux2 = 1;
    push(5, 32'h12345678);
    for (int i = 0; i < 12; i++) begin srcHold = ~srcHold; cyc(1); end
    srcHold = 0;
    drain();
    chk(lenHist[$] == 5, "R10", "gaps below limit keep frame", lenHist[$], 5);
    localStop = 0; txOvf = 0; notReadyLvl = 1;

    // long stream splits at the bound
    stallLimit = 8'd0;
    lenHist.delete();
    push(MAXW + 3, 32'h0BADF00D);
    drain();
    chk(lenHist.size() == 2, "R9", "frame count", lenHist.size(), 2);
    if (lenHist.size() == 2) begin
      chk(lenHist[0] == MAXW, "R9", "full frame", lenHist[0], MAXW);
      chk(lenHist[1] == 3, "R9", "remainder frame", lenHist[1], 3);
    end
    notReadyLvl = 0; stallLimit = 8'd4;

    // bare sync
    syncBare = 1;
    cyc(20);
    chk(lenHist[$] == 0, "R4", "bare sync words", lenHist[$], 0);
    chk(lastClose == 10, "R4", "sync close", lastClose, 10);

    // sync with data, ahead of queued words
    push(3, 32'hC0DE0000);
    syncData = 1;
    drain();
    chk(lenHist[$-1] == 1, "R3", "sync word count", lenHist[$-1], 1);
    chk(lenHist[$] == 2, "R13", "data after sync", lenHist[$], 2);

    // illegal combination
    s0 = sofCount; e0 = errCount;
    syncBare = 1; syncData = 1;
    cyc(10);
    chk(errCount == e0 + 1, "R12", "error pulses", errCount, e0 + 1);
    chk(sofCount == s0, "R12", "no frame", sofCount, s0);

    // held off by far end, then by link down
    flowEn = 1; remoteStop = 1;
    s0 = sofCount;
    push(2, 32'h5500AA00);
    cyc(20);
    chk(sofCount == s0, "R11", "held by stop", sofCount, s0);
    remoteStop = 0; linkUp = 0;
    cyc(20);
    chk(sofCount == s0, "R11", "held by link down", sofCount, s0);
    linkUp = 1;
    drain();
    chk(sofCount == s0 + 1, "R11", "released", sofCount, s0 + 1);

    // stop arriving mid-frame
    stallLimit = 8'd10;
    push(4, 32'h77770000);
    cyc(3);
    remoteStop = 1;
    drain();
    chk(lenHist[$] == 4, "R11", "frame completes", lenHist[$], 4);
    s0 = sofCount;
    push(1, 32'h99999999);
    cyc(20);
    chk(sofCount == s0, "R11", "new frame held", sofCount, s0);
    flowEn = 0;
    drain();
    chk(sofCount == s0 + 1, "R11", "ignored when disabled", sofCount, s0 + 1);
    remoteStop = 0;

    cyc(5);
    summary();
  end

endmodule